// File: doc/BRIEF.md
# In-Order Pipeline Commit Stage

The commit stage is the last stage of a single-issue, in-order pipeline and the only place where an instruction becomes architecturally visible. Each cycle it takes one slot from the stage before it: a valid bit, a fault flag, a privileged-call flag with an 8-bit function code, a store flag with a physical address and 64-bit data, and a branch-taken flag with the branch PC and its resolved target.

It settles every slot by fixed priority. A pending fault wins and yields only a fault pulse. Next comes a privileged call, which yields only a call pulse and a handler entry vector. Anything else is committed: a store is written to memory and kills a matching load-linked reservation, a taken branch updates the predictor, and the retired-instruction count goes up. The stage holds a one-entry reservation tracker that a load-linked operation arms. It never writes the register file, because the memory stage writes results earlier so that they can be forwarded.

All results are registered. They appear one clock after the slot is presented and are cleared in the next cycle unless another slot supplies new ones.

Top module: `commit_stage`

## Requirements
- R1: A valid slot with the fault flag set produces `fault_o` high for exactly one cycle, one clock later. It produces no call pulse (even if the call flag is also set), no memory write, no predictor update and no retire count change.
- R2: A valid slot without a fault but with the call flag set produces `pcall_o` for one cycle, one clock later. It produces no memory write, no predictor update and no retire count change, even when the store or branch flags are set.
- R3: The handler vector on `pcall_vec_o` equals `pal_base_i + region + (func[6:0] * 64)`, where region is 0 when `func[7]` is 0 and 0x2000 when `func[7]` is 1.
- R4: A valid slot with no fault and no call that has the store flag set drives `mem_we_o` for one cycle, one clock later, with `mem_addr_o` and `mem_data_o` equal to the slot's address and data.
- R5: Each committed store pulses `resv_kill_o` together with `mem_we_o`. It clears the reservation when address bits [47:6] of the store equal the held line (bits [5:0] are ignored). A reservation on a different line is kept.
- R6: `ll_set_i` arms the reservation with line `ll_addr_i[47:6]`, visible on `resv_valid_o`/`resv_line_o` one clock later. When a matching store kill occurs in the same cycle, the new arm wins.
- R7: A committed slot with the branch flag set drives `bp_upd_o` for one cycle, one clock later, with `bp_pc_o` and `bp_tgt_o` equal to the slot's branch PC and target.
- R8: `retired_o` increases by exactly one, modulo 2^32, one clock after each committed slot, and holds otherwise.
- R9: In the cycle after a clock with no valid slot, every pulse output is low and every payload output (`pcall_vec_o`, `mem_addr_o`, `mem_data_o`, `bp_pc_o`, `bp_tgt_o`) is zero.
- R10: While `rst_n` is low at a clock edge, all pulse and payload outputs become zero, the reservation becomes invalid with line zero, and `retired_o` becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Slot holds an instruction |
| in_fault | input | 1 | Slot carries a pending fault |
| in_pcall | input | 1 | Slot is a privileged call |
| in_store | input | 1 | Slot is a store |
| in_br_taken | input | 1 | Slot is a taken branch |
| in_func | input | 8 | Privileged-call function code |
| in_pa | input | 48 | Store physical address |
| in_data | input | 64 | Store data |
| in_br_pc | input | 64 | Branch PC |
| in_br_tgt | input | 64 | Resolved branch target |
| pal_base_i | input | 64 | Handler region base |
| ll_set_i | input | 1 | Arm the load-linked reservation |
| ll_addr_i | input | 48 | Load-linked address |
| fault_o | output | 1 | Fault action pulse |
| pcall_o | output | 1 | Privileged-call action pulse |
| pcall_vec_o | output | 64 | Handler entry vector |
| mem_we_o | output | 1 | 64-bit memory write strobe |
| mem_addr_o | output | 48 | Write address |
| mem_data_o | output | 64 | Write data |
| resv_kill_o | output | 1 | Reservation kill pulse |
| resv_valid_o | output | 1 | Reservation held |
| resv_line_o | output | 42 | Reserved line address |
| bp_upd_o | output | 1 | Predictor update strobe |
| bp_pc_o | output | 64 | Update PC |
| bp_tgt_o | output | 64 | Update target |
| retired_o | output | 32 | Retired-instruction count |

## Verification
Every result of this block, including the action pulses, memory write, kill, predictor update, reservation state and retire count, is due exactly one clock after the inputs that cause it. The bench drives a slot at a falling edge, lets one rising edge pass and compares at the next falling edge. Before that comparison, its reference model has already advanced by exactly one step. Outputs are compared every cycle, so a pulse that lasts too long or arrives a cycle late shows up as a mismatch in the neighbouring cycle.

// File: rtl/commit_pkg.sv
// Package: shared types of the commit stage.
// Assumes: one slot per cycle; the action set is closed.
package commit_pkg;

    // Outcome of the priority decision for one slot.
    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_FAULT  = 2'd1,
        ACT_PCALL  = 2'd2,
        ACT_COMMIT = 2'd3
    } act_e;

    // Decision bundle produced by the arbiter.
    typedef struct packed {
        act_e act;
        logic do_store;
        logic do_bp;
        logic do_retire;
    } decision_t;

endpackage

// File: rtl/cs_arbiter.sv
// Module: cs_arbiter
// Resolves one slot into a single action: fault beats call, call beats commit.
// Only the commit action may write memory, update the predictor or retire.
// Assumes: purely combinational; the caller registers the result.
module cs_arbiter
    import commit_pkg::*;
(
    input  logic      valid_i,
    input  logic      fault_i,
    input  logic      pcall_i,
    input  logic      store_i,
    input  logic      br_i,
    output decision_t dec_o
);

    // Priority decision and commit-side enables.
    always_comb begin
        dec_o = '0;
        if (!valid_i) begin
            dec_o.act = ACT_IDLE;
        end else if (fault_i) begin
            dec_o.act = ACT_FAULT;
        end else if (pcall_i) begin
            dec_o.act = ACT_PCALL;
        end else begin
            dec_o.act       = ACT_COMMIT;
            dec_o.do_store  = store_i;
            dec_o.do_bp     = br_i;
            dec_o.do_retire = 1'b1;
        end
    end

endmodule

// File: rtl/cs_vector.sv
// Module: cs_vector
// Forms the handler entry vector: base + region offset + (code low bits << SHIFT).
// The top bit of the function code selects the unprivileged region.
// Assumes: combinational; FUNC_W >= 2.
module cs_vector #(
    parameter int                VEC_W      = 64,
    parameter int                FUNC_W     = 8,
    parameter int                SHIFT      = 6,
    parameter logic [VEC_W-1:0]  PRIV_OFS   = '0,
    parameter logic [VEC_W-1:0]  UNPRIV_OFS = VEC_W'(32'h2000)
) (
    input  logic [VEC_W-1:0]  base_i,
    input  logic [FUNC_W-1:0] func_i,
    output logic [VEC_W-1:0]  vec_o
);

    localparam int IDX_W = FUNC_W - 1;

    logic [IDX_W-1:0] idx;
    logic [VEC_W-1:0] region;
    logic [VEC_W-1:0] scaled;

    // Split code into region select and entry index.
    always_comb begin
        idx    = func_i[IDX_W-1:0];
        region = func_i[FUNC_W-1] ? UNPRIV_OFS : PRIV_OFS;
        scaled = VEC_W'(idx) << SHIFT;
    end

    // Final vector sum.
    always_comb begin
        vec_o = base_i + region + scaled;
    end

endmodule

// File: rtl/cs_resv.sv
// Module: cs_resv
// One-entry load-linked reservation tracker: a valid bit and a line address.
// A kill clears the entry only when its line matches; an arm in the same cycle wins.
// Assumes: synchronous active-low reset; LINE_B low address bits select a byte in a line.
module cs_resv #(
    parameter int PA_W   = 48,
    parameter int LINE_B = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   kill_i,
    input  logic [PA_W-1:0]        kill_addr_i,
    input  logic                   set_i,
    input  logic [PA_W-1:0]        set_addr_i,
    output logic                   valid_o,
    output logic [PA_W-LINE_B-1:0] line_o
);

    localparam int LINE_W = PA_W - LINE_B;

    logic              hit;
    logic [LINE_W-1:0] kill_line;
    logic [LINE_W-1:0] set_line;

    // Line extraction and match.
    always_comb begin
        kill_line = kill_addr_i[PA_W-1:LINE_B];
        set_line  = set_addr_i[PA_W-1:LINE_B];
        hit       = valid_o && (kill_line == line_o);
    end

    // Reservation state: arm has priority over a matching kill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            line_o  <= '0;
        end else if (set_i) begin
            valid_o <= 1'b1;
            line_o  <= set_line;
        end else if (kill_i && hit) begin
            valid_o <= 1'b0;
        end
    end

endmodule

// File: rtl/cs_retire_ctr.sv
// Module: cs_retire_ctr
// Counts committed instructions, wrapping modulo 2^CNT_W.
// Assumes: synchronous active-low reset; at most one retirement per cycle.
module cs_retire_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (inc_i) begin
            count_o <= count_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/commit_stage.sv
// Module: commit_stage
// Final stage of an in-order pipeline. It decides by priority between fault dispatch,
// privileged-call entry and commit. On commit it writes stores, kills a matching
// reservation, updates the predictor and counts retirement.
// Results are registered and appear one clock after the slot. With no new slot they
// clear on the next clock. The register file is never written here.
// Assumes: synchronous active-low reset; one slot per cycle.
module commit_stage
    import commit_pkg::*;
#(
    parameter int PA_W   = 48,
    parameter int VA_W   = 64,
    parameter int DATA_W = 64,
    parameter int CNT_W  = 32,
    parameter int FUNC_W = 8,
    parameter int LINE_B = 6,
    parameter int VEC_SH = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_fault,
    input  logic                   in_pcall,
    input  logic                   in_store,
    input  logic                   in_br_taken,
    input  logic [FUNC_W-1:0]      in_func,
    input  logic [PA_W-1:0]        in_pa,
    input  logic [DATA_W-1:0]      in_data,
    input  logic [VA_W-1:0]        in_br_pc,
    input  logic [VA_W-1:0]        in_br_tgt,
    input  logic [VA_W-1:0]        pal_base_i,
    input  logic                   ll_set_i,
    input  logic [PA_W-1:0]        ll_addr_i,
    output logic                   fault_o,
    output logic                   pcall_o,
    output logic [VA_W-1:0]        pcall_vec_o,
    output logic                   mem_we_o,
    output logic [PA_W-1:0]        mem_addr_o,
    output logic [DATA_W-1:0]      mem_data_o,
    output logic                   resv_kill_o,
    output logic                   resv_valid_o,
    output logic [PA_W-LINE_B-1:0] resv_line_o,
    output logic                   bp_upd_o,
    output logic [VA_W-1:0]        bp_pc_o,
    output logic [VA_W-1:0]        bp_tgt_o,
    output logic [CNT_W-1:0]       retired_o
);

    decision_t       dec;
    logic [VA_W-1:0] vec;
    logic            st_en;

    cs_arbiter u_arb (
        .valid_i (in_valid),
        .fault_i (in_fault),
        .pcall_i (in_pcall),
        .store_i (in_store),
        .br_i    (in_br_taken),
        .dec_o   (dec)
    );

    cs_vector #(
        .VEC_W  (VA_W),
        .FUNC_W (FUNC_W),
        .SHIFT  (VEC_SH)
    ) u_vec (
        .base_i (pal_base_i),
        .func_i (in_func),
        .vec_o  (vec)
    );

    // Store enable shared by the write port and the reservation kill.
    always_comb begin
        st_en = (dec.act == ACT_COMMIT) && dec.do_store;
    end

    cs_resv #(
        .PA_W   (PA_W),
        .LINE_B (LINE_B)
    ) u_resv (
        .clk         (clk),
        .rst_n       (rst_n),
        .kill_i      (st_en),
        .kill_addr_i (in_pa),
        .set_i       (ll_set_i),
        .set_addr_i  (ll_addr_i),
        .valid_o     (resv_valid_o),
        .line_o      (resv_line_o)
    );

    cs_retire_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (dec.do_retire),
        .count_o (retired_o)
    );

    // Action pulses: one flop each, cleared every cycle without a matching slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_o     <= 1'b0;
            pcall_o     <= 1'b0;
            pcall_vec_o <= '0;
        end else begin
            fault_o     <= (dec.act == ACT_FAULT);
            pcall_o     <= (dec.act == ACT_PCALL);
            pcall_vec_o <= (dec.act == ACT_PCALL) ? vec : '0;
        end
    end

    // Store write port and reservation kill pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we_o    <= 1'b0;
            mem_addr_o  <= '0;
            mem_data_o  <= '0;
            resv_kill_o <= 1'b0;
        end else begin
            mem_we_o    <= st_en;
            resv_kill_o <= st_en;
            mem_addr_o  <= st_en ? in_pa   : '0;
            mem_data_o  <= st_en ? in_data : '0;
        end
    end

    // Branch predictor update port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_upd_o <= 1'b0;
            bp_pc_o  <= '0;
            bp_tgt_o <= '0;
        end else begin
            bp_upd_o <= dec.do_bp;
            bp_pc_o  <= dec.do_bp ? in_br_pc  : '0;
            bp_tgt_o <= dec.do_bp ? in_br_tgt : '0;
        end
    end

endmodule

// File: rtl/commit_stage_chk.sv
// Module: commit_stage_chk
// Temporal checks on the commit stage ports, attached by bind.
// Assumes: synchronous active-low reset; all checks are disabled while it is low.
module commit_stage_chk #(
    parameter int PA_W   = 48,
    parameter int LINE_B = 6,
    parameter int CNT_W  = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   in_fault,
    input logic                   in_pcall,
    input logic                   ll_set_i,
    input logic                   fault_o,
    input logic                   pcall_o,
    input logic                   mem_we_o,
    input logic [PA_W-1:0]        mem_addr_o,
    input logic                   resv_kill_o,
    input logic                   resv_valid_o,
    input logic [PA_W-LINE_B-1:0] resv_line_o,
    input logic                   bp_upd_o,
    input logic [CNT_W-1:0]       retired_o
);

    // At most one of the exclusive actions per cycle (R1, R2).
    assert_one_action_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_o, pcall_o, mem_we_o}));

    // A fault leaves the retire count unchanged (R1).
    assert_fault_no_retire_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (retired_o == $past(retired_o)));

    // A call neither writes nor updates the predictor (R2).
    assert_pcall_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pcall_o |-> (!mem_we_o && !bp_upd_o && retired_o == $past(retired_o)));

    // A faulting slot produces a fault pulse next cycle (R1).
    assert_fault_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fault) |=> fault_o);

    // Every store write carries a reservation kill (R5).
    assert_store_kills_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> resv_kill_o);

    // A matching kill with no arm leaves the reservation invalid (R5).
    assert_match_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resv_kill_o && $past(resv_valid_o) && !$past(ll_set_i)
         && mem_addr_o[PA_W-1:LINE_B] == $past(resv_line_o)) |-> !resv_valid_o);

    // An arm always leaves a valid reservation (R6).
    assert_arm_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ll_set_i |=> resv_valid_o);

    // The counter moves by at most one per cycle (R8).
    assert_step_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (retired_o != $past(retired_o)) |-> (retired_o == $past(retired_o) + CNT_W'(1)));

    // Pulses do not repeat without a new slot (R9).
    assert_pulse_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!fault_o && !pcall_o && !mem_we_o && !bp_upd_o));

endmodule

bind commit_stage commit_stage_chk #(
    .PA_W   (PA_W),
    .LINE_B (LINE_B),
    .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/sim_commit_stage.sv
// Bench for commit_stage: a behavioural model predicts every output one clock ahead
// and is compared at each falling edge.
module sim_commit_stage;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_fault, in_pcall, in_store, in_br_taken;
    logic [7:0]  in_func;
    logic [47:0] in_pa;
    logic [63:0] in_data, in_br_pc, in_br_tgt, pal_base_i;
    logic        ll_set_i;
    logic [47:0] ll_addr_i;
    logic        fault_o, pcall_o, mem_we_o, resv_kill_o, resv_valid_o, bp_upd_o;
    logic [63:0] pcall_vec_o, mem_data_o, bp_pc_o, bp_tgt_o;
    logic [47:0] mem_addr_o;
    logic [41:0] resv_line_o;
    logic [31:0] retired_o;

    commit_stage u0 (.*);

    always #2 clk = ~clk;

    int total = 0;
    int bad   = 0;

    // Model state and expected outputs.
    logic        m_rv;
    logic [41:0] m_rl;
    logic [31:0] m_cnt;
    logic        e_fault, e_pcall, e_we, e_kill, e_bp;
    logic [63:0] e_vec, e_data, e_bppc, e_bptgt;
    logic [47:0] e_addr;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(fault_o === e_fault, "R1 fault_o", 64'(fault_o), 64'(e_fault));
        chk(pcall_o === e_pcall, "R2 pcall_o", 64'(pcall_o), 64'(e_pcall));
        chk(pcall_vec_o === e_vec, "R3 pcall_vec_o", pcall_vec_o, e_vec);
        chk(mem_we_o === e_we, "R4 mem_we_o", 64'(mem_we_o), 64'(e_we));
        chk(mem_addr_o === e_addr, "R4 mem_addr_o", 64'(mem_addr_o), 64'(e_addr));
        chk(mem_data_o === e_data, "R4 mem_data_o", mem_data_o, e_data);
        chk(resv_kill_o === e_kill, "R5 resv_kill_o", 64'(resv_kill_o), 64'(e_kill));
        chk(resv_valid_o === m_rv, "R6 resv_valid_o", 64'(resv_valid_o), 64'(m_rv));
        chk(resv_line_o === m_rl, "R6 resv_line_o", 64'(resv_line_o), 64'(m_rl));
        chk(bp_upd_o === e_bp, "R7 bp_upd_o", 64'(bp_upd_o), 64'(e_bp));
        chk(bp_pc_o === e_bppc, "R7 bp_pc_o", bp_pc_o, e_bppc);
        chk(bp_tgt_o === e_bptgt, "R7 bp_tgt_o", bp_tgt_o, e_bptgt);
        chk(retired_o === m_cnt, "R8 retired_o", 64'(retired_o), 64'(m_cnt));
    endtask

    // Clear expected pulses and payloads (R9 and R10 behaviour).
    task automatic clear_exp();
        e_fault = 0; e_pcall = 0; e_we = 0; e_kill = 0; e_bp = 0;
        e_vec = 0; e_data = 0; e_bppc = 0; e_bptgt = 0; e_addr = 0;
    endtask

    // Drive one slot at a falling edge, advance the model, compare one clock later.
    task automatic slot(input bit v, input bit f, input bit p, input bit s, input bit b,
                        input logic [7:0] fn, input logic [47:0] pa, input logic [63:0] d,
                        input bit lls, input logic [47:0] lla);
        in_valid = v; in_fault = f; in_pcall = p; in_store = s; in_br_taken = b;
        in_func = fn; in_pa = pa; in_data = d; ll_set_i = lls; ll_addr_i = lla;
        in_br_pc  = {16'hB0B0, pa};
        in_br_tgt = d ^ 64'h5555_0000_FFFF_0000;
        clear_exp();
        if (v) begin
            if (f) begin
                e_fault = 1;
            end else if (p) begin
                e_pcall = 1;
                e_vec = pal_base_i + (fn[7] ? 64'h2000 : 64'h0) + 64'(fn[6:0]) * 64;
            end else begin
                if (s) begin
                    e_we = 1; e_kill = 1; e_addr = pa; e_data = d;
                    if (m_rv && (pa / 64) == 48'(m_rl)) m_rv = 0;
                end
                if (b) begin
                    e_bp = 1; e_bppc = in_br_pc; e_bptgt = in_br_tgt;
                end
                m_cnt = m_cnt + 1;
            end
        end
        if (lls) begin
            m_rv = 1;
            m_rl = 42'(lla / 64);
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        slot(0, 0, 0, 0, 0, 8'h00, 48'h0, 64'h0, 0, 48'h0);
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0;
        in_valid = 1; in_fault = 1; in_pcall = 0; in_store = 1; in_br_taken = 1;
        in_func = 0; in_pa = 0; in_data = 0; in_br_pc = 0; in_br_tgt = 0;
        pal_base_i = 64'h0000_0000_8000_0000;
        ll_set_i = 1; ll_addr_i = 48'h1234;
        m_rv = 0; m_rl = 0; m_cnt = 0;
        clear_exp();
        // R10: held reset clears everything despite busy inputs.
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
            compare_all();
        end
        rst_n = 1;
        idle();

        // R1: fault alone, then fault with call, store and branch set.
        slot(1, 1, 0, 0, 0, 8'h00, 48'h100, 64'h1, 0, 48'h0);
        slot(1, 1, 1, 1, 1, 8'h05, 48'h140, 64'h2, 0, 48'h0);
        // R9: cleared cycle after.
        idle();
        // R2 and R3: privileged and unprivileged codes, store/branch flags ignored.
        slot(1, 0, 1, 0, 0, 8'h03, 48'h0, 64'h0, 0, 48'h0);
        slot(1, 0, 1, 1, 1, 8'h83, 48'h200, 64'h3, 0, 48'h0);
        slot(1, 0, 1, 0, 0, 8'hFF, 48'h0, 64'h0, 0, 48'h0);
        pal_base_i = 64'h0000_0010_0000_0040;
        slot(1, 0, 1, 0, 0, 8'h7F, 48'h0, 64'h0, 0, 48'h0);
        // R6: arm a reservation; R5: store to another line keeps it.
        slot(0, 0, 0, 0, 0, 8'h00, 48'h0, 64'h0, 1, 48'h0000_1000_0008);
        slot(1, 0, 0, 1, 0, 8'h00, 48'h0000_1000_0040, 64'hAAAA, 0, 48'h0);
        // R5: same line, different byte offset clears it.
        slot(1, 0, 0, 1, 0, 8'h00, 48'h0000_1000_003F, 64'hBBBB, 0, 48'h0);
        // R6: arm and matching store in the same cycle, arm wins.
        slot(0, 0, 0, 0, 0, 8'h00, 48'h0, 64'h0, 1, 48'h0000_2000_0000);
        slot(1, 0, 0, 1, 0, 8'h00, 48'h0000_2000_0010, 64'hCCCC, 1, 48'h0000_2000_0020);
        // R7 and R8: taken branch, then store plus branch.
        slot(1, 0, 0, 0, 1, 8'h00, 48'h300, 64'h77, 0, 48'h0);
        slot(1, 0, 0, 1, 1, 8'h00, 48'h340, 64'h88, 0, 48'h0);
        // R8: plain commit with no side effects still retires.
        slot(1, 0, 0, 0, 0, 8'h00, 48'h0, 64'h0, 0, 48'h0);
        idle();

        // Mixed traffic across all requirements on a few shared lines.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            slot(r[0], r[1] & r[2], r[3], r[4], r[5], r[15:8],
                 48'h0000_5000_0000 + 48'(r[17:16]) * 64 + 48'(r[23:18]),
                 {$urandom, $urandom}, r[24] & r[25],
                 48'h0000_5000_0000 + 48'(r[27:26]) * 64 + 48'(r[31:28]));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule